// File: doc/BRIEF.md
# Constant-Pattern Memory Fill Engine

This block paints a byte range of memory with one repeated colour value. Software, or a command processor, sets the start address, the end address, the colour and a pattern width in a channel's registers, then sets that channel's trigger bit. The block checks the range and then writes the pattern from the start address upward through a 32-bit memory write port with byte enables. When the fill ends it clears the trigger bit, pulses a done flag and, if allowed, raises that channel's completion interrupt.

There are `NCH` identical channels, two by default. All channels share one sequencer and one memory port. Only one fill runs at a time, and when several triggers are pending the channel with the lowest index goes first.

The pattern width can be 2, 3 or 4 bytes. A pattern does not have to be aligned to a word. When it crosses a word boundary it goes out as two word writes, and each write carries only the byte enables of the lanes it covers.

The sequencer has six states:

| State | Role |
|---|---|
| IDLE | Waits for a pending trigger. |
| SETUP | Loads the chosen channel's start address. |
| STEP | Decides whether another pattern is due. |
| WLO | Writes the word that holds the pattern's first byte. |
| WHI | Writes the following word. |
| FINISH | Issues done and the interrupt, and clears the trigger. |

Its transitions are:

- IDLE→SETUP on any pending trigger.
- SETUP→STEP, always.
- STEP→WLO when another pattern is due.
- STEP→FINISH when none is due.
- WLO→WHI on an accepted write whose pattern spills into the next word.
- WLO→STEP on an accepted write that ends the pattern.
- WHI→STEP on an accepted write.
- FINISH→IDLE, always.

Top module: `fill_engine`

## Requirements
- R1: A trigger whose end address is at or below its start address performs no memory write and raises no interrupt. It still pulses done and clears the trigger bit.
- R2: When control bits 1 and 2 are both clear, the block writes value[15:0] as two bytes every 2 bytes while the current address is below the end.
- R3: When control bit 1 is set, the block writes value[7:0], value[15:8] and value[23:16] to three ascending bytes, then steps the address by 3. It continues while the current address is below the end, so the last pattern may pass the end by up to 2 bytes.
- R4: When only control bit 2 is set, the block writes floor((end-start)/4) whole 4-byte copies of value from start. It does not write a trailing partial word.
- R5: When control bits 1 and 2 are both set, the block behaves as in R3.
- R6: Patterns are stored little-endian. Each write has mem_addr[1:0]=0 and a non-zero mem_be. A pattern that crosses a word boundary is sent as two writes, the lower address first. While mem_ack is low, mem_req, mem_addr, mem_be and mem_wdata hold their values.
- R7: Each channel has its own irq bit. The bit is a one-cycle pulse that coincides with that channel's done pulse, 2 cycles after the cycle in which the last write was accepted. It is suppressed when the start address is 0.
- R8: trig_o of a channel goes to 0 in the cycle after its done pulse.
- R9: While a channel is being filled, register writes to that channel are ignored, including a new trigger. A trigger on another channel stays pending and runs after the current fill, lowest index first.
- R10: After reset, busy, mem_req, trig_o, done and irq are all 0.
- R11: Configuration registers are selected by cfg_reg: 0 is the start address, 1 is the end address, 2 is the value, and 3 is control. Control bit 0 is the trigger, bit 1 selects the 3-byte pattern, and bit 2 selects the 4-byte pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel selected by the register write |
| cfg_reg | input | 2 | Register selected by the register write |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Write accepted in this cycle |
| trig_o | output | NCH | Trigger bit of each channel |
| busy | output | 1 | A fill is in progress |
| done | output | NCH | One-cycle completion pulse per channel |
| irq | output | NCH | One-cycle completion interrupt per channel |

## Verification
A register write presented in one cycle takes effect at the next clock edge. The fill starts two edges after that, through the IDLE and SETUP states. The done and irq pulses stand in the second cycle after the cycle in which the last write was accepted, and trig_o falls in the cycle after that. The bench keeps a byte memory that it updates only on cycles where mem_req and mem_ack are both high, and it inserts regular stalls on mem_ack. It samples every output at the falling edge and checks the pulse distance from its recorded last-accept cycle. It then compares the whole memory with an arithmetic model of every pattern width, start offset and length, including empty and inverted ranges.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_STEP, S_WLO, S_WHI, S_FINISH
    } fill_state_e;

    typedef enum logic [1:0] {
        GR_16 = 2'd0,
        GR_24 = 2'd1,
        GR_32 = 2'd2
    } fill_gran_e;

    localparam int CTRL_TRIG = 0;
    localparam int CTRL_G24  = 1;
    localparam int CTRL_G32  = 2;

    // The 3-byte flag wins over the 4-byte flag.
    function automatic fill_gran_e decode_gran(input logic g24, input logic g32);
        if (g24)      return GR_24;
        else if (g32) return GR_32;
        else          return GR_16;
    endfunction

    function automatic logic [2:0] gran_stride(input fill_gran_e g);
        unique case (g)
            GR_24:   return 3'd3;
            GR_32:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [3:0] gran_mask(input fill_gran_e g);
        unique case (g)
            GR_24:   return 4'b0111;
            GR_32:   return 4'b1111;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fill_cfg_bank.sv
module fill_cfg_bank
    import fill_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          locked,
    input  logic          clr_trig,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] end_o,
    output logic [31:0]   value_o,
    output fill_gran_e    gran_o,
    output logic          trig_o
);

    logic g24_q, g32_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
            end_o   <= '0;
            value_o <= '0;
            g24_q   <= 1'b0;
            g32_q   <= 1'b0;
            trig_o  <= 1'b0;
        end else begin
            if (clr_trig) trig_o <= 1'b0;
            if (wr_en && !locked) begin
                unique case (wr_sel)
                    2'd0: start_o <= wr_data[AW-1:0];
                    2'd1: end_o   <= wr_data[AW-1:0];
                    2'd2: value_o <= wr_data;
                    default: begin
                        trig_o <= wr_data[CTRL_TRIG];
                        g24_q  <= wr_data[CTRL_G24];
                        g32_q  <= wr_data[CTRL_G32];
                    end
                endcase
            end
        end
    end

    assign gran_o = decode_gran(g24_q, g32_q);

endmodule

// File: rtl/fill_lane_map.sv
module fill_lane_map
    import fill_pkg::*;
(
    input  logic [1:0]  lane,
    input  logic [31:0] value,
    input  fill_gran_e  gran,
    output logic [31:0] lo_data,
    output logic [3:0]  lo_be,
    output logic [31:0] hi_data,
    output logic [3:0]  hi_be,
    output logic        need_hi
);

    logic [3:0]  bmask;
    logic [31:0] vmask;
    logic [63:0] window;
    logic [7:0]  be_win;

    assign bmask = gran_mask(gran);

    for (genvar b = 0; b < 4; b++) begin : g_vmask
        assign vmask[8*b +: 8] = bmask[b] ? value[8*b +: 8] : 8'h00;
    end

    assign window  = {32'h0, vmask} << {lane, 3'b000};
    assign be_win  = {4'h0, bmask} << lane;
    assign lo_data = window[31:0];
    assign hi_data = window[63:32];
    assign lo_be   = be_win[3:0];
    assign hi_be   = be_win[7:4];
    assign need_hi = |be_win[7:4];

endmodule

// File: rtl/fill_seq.sv
module fill_seq
    import fill_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic [AW-1:0]  start_a [NCH],
    input  logic [AW-1:0]  end_a   [NCH],
    input  logic [31:0]    value_a [NCH],
    input  fill_gran_e     gran_a  [NCH],
    input  logic           mem_ack,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    output logic [3:0]     mem_be,
    output logic           busy,
    output logic [NCH-1:0] done,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] lock
);

    fill_state_e    state;
    logic [CHW-1:0] ch, pick;
    logic [AW-1:0]  addr;
    logic           found;

    logic [AW-1:0] cur_start, cur_end;
    logic [31:0]   cur_value;
    fill_gran_e    cur_gran;
    logic [AW-1:0] stride;
    logic          more;
    logic [31:0]   lo_data, hi_data;
    logic [3:0]    lo_be, hi_be;
    logic          need_hi;

    // Fixed priority: the lowest pending index is chosen.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (pend[i] && !found) begin
                pick  = CHW'(i);
                found = 1'b1;
            end
        end
    end

    assign cur_start = start_a[ch];
    assign cur_end   = end_a[ch];
    assign cur_value = value_a[ch];
    assign cur_gran  = gran_a[ch];
    assign stride    = AW'(gran_stride(cur_gran));

    // A 4-byte pattern must fit entirely; narrower patterns only need a start below end.
    assign more = (cur_gran == GR_32)
                ? (({1'b0, addr} + (AW+1)'(4)) <= {1'b0, cur_end})
                : (addr < cur_end);

    fill_lane_map u_lane (
        .lane    (addr[1:0]),
        .value   (cur_value),
        .gran    (cur_gran),
        .lo_data (lo_data),
        .lo_be   (lo_be),
        .hi_data (hi_data),
        .hi_be   (hi_be),
        .need_hi (need_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ch    <= '0;
            addr  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (found) begin
                    ch    <= pick;
                    state <= S_SETUP;
                end
                S_SETUP: begin
                    addr  <= cur_start;
                    state <= S_STEP;
                end
                S_STEP: state <= more ? S_WLO : S_FINISH;
                S_WLO: if (mem_ack) begin
                    if (need_hi) state <= S_WHI;
                    else begin
                        addr  <= addr + stride;
                        state <= S_STEP;
                    end
                end
                S_WHI: if (mem_ack) begin
                    addr  <= addr + stride;
                    state <= S_STEP;
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = 1'b0;
        mem_addr  = {addr[AW-1:2], 2'b00};
        mem_wdata = lo_data;
        mem_be    = lo_be;
        done      = '0;
        irq       = '0;
        lock      = '0;
        if (busy) lock[ch] = 1'b1;
        unique case (state)
            S_WLO: mem_req = 1'b1;
            S_WHI: begin
                mem_req   = 1'b1;
                mem_addr  = {addr[AW-1:2], 2'b00} + AW'(4);
                mem_wdata = hi_data;
                mem_be    = hi_be;
            end
            S_FINISH: begin
                done[ch] = 1'b1;
                irq[ch]  = (cur_start != '0) && (cur_end > cur_start);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_reg,
    input  logic [31:0]    cfg_wdata,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    output logic [3:0]     mem_be,
    input  logic           mem_ack,
    output logic [NCH-1:0] trig_o,
    output logic           busy,
    output logic [NCH-1:0] done,
    output logic [NCH-1:0] irq
);

    logic [AW-1:0]  start_a [NCH];
    logic [AW-1:0]  end_a   [NCH];
    logic [31:0]    value_a [NCH];
    fill_gran_e     gran_a  [NCH];
    logic [NCH-1:0] lock;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        fill_cfg_bank #(.AW(AW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_ch == CHW'(g))),
            .wr_sel   (cfg_reg),
            .wr_data  (cfg_wdata),
            .locked   (lock[g]),
            .clr_trig (done[g]),
            .start_o  (start_a[g]),
            .end_o    (end_a[g]),
            .value_o  (value_a[g]),
            .gran_o   (gran_a[g]),
            .trig_o   (trig_o[g])
        );
    end

    fill_seq #(.NCH(NCH), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (trig_o),
        .start_a   (start_a),
        .end_a     (end_a),
        .value_a   (value_a),
        .gran_a    (gran_a),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .lock      (lock)
    );

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
    parameter int NCH = 2,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic [AW-1:0]  mem_addr,
    input logic [31:0]    mem_wdata,
    input logic [3:0]     mem_be,
    input logic           mem_ack,
    input logic [NCH-1:0] trig_o,
    input logic           busy,
    input logic [NCH-1:0] done,
    input logic [NCH-1:0] irq
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R6

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00) && (mem_be != 4'h0)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_be) && $stable(mem_wdata)); // R6

    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~done) == '0); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> (done == '0)); // R7

    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done)); // R9

    AST_TRIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> ((trig_o & $past(done)) == '0)); // R8

endmodule

bind fill_engine fill_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack),
    .trig_o    (trig_o),
    .busy      (busy),
    .done      (done),
    .irq       (irq)
);

// File: tb/fill_engine_tb_top.sv
`timescale 1ns/1ps
module fill_engine_tb_top;

    localparam int NCH = 2;
    localparam int AW  = 32;
    localparam int MSZ = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_ch = '0;
    logic [1:0]    cfg_reg = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          mem_ack = 1'b1;
    logic [1:0]    trig_o, done, irq;
    logic          busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int last_cap = 0;
    int nwr = 0;
    logic [7:0] mem_model [MSZ];
    logic [7:0] init_img  [MSZ];

    always #2.5 clk = ~clk;

    fill_engine #(.NCH(NCH), .AW(AW)) dut_i (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One falling edge: set ack for the next edge, then record a write that edge will accept.
    task automatic tick();
        @(negedge clk);
        cyc++;
        ack_cnt++;
        mem_ack = (ack_cnt % 4) != 1;
        if (mem_req && mem_ack) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem_model[(int'(mem_addr[5:0]) + b) % MSZ] = mem_wdata[8*b +: 8];
            last_cap = cyc;
            nwr++;
        end
    endtask

    task automatic cfg_wr(input int ch, input int r, input logic [31:0] d);
        tick();
        cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_reg = 2'(r); cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic launch(input int ch, input int s, input int e, input logic [31:0] v, input int m);
        cfg_wr(ch, 0, 32'(s));
        cfg_wr(ch, 1, 32'(e));
        cfg_wr(ch, 2, v);
        cfg_wr(ch, 3, {29'b0, (m == 2 || m == 3), (m == 1 || m == 3), 1'b1});
    endtask

    function automatic logic [7:0] exp_byte(input int j, input int s, input int e,
                                            input logic [31:0] v, input int m, input logic [7:0] old);
        int w, n;
        w = (m == 0) ? 2 : (m == 2) ? 4 : 3;
        if (e <= s) return old;
        n = (m == 2) ? (e - s) / 4 : (e - s + w - 1) / w;
        if (j >= s && j < s + n * w) return v[8*((j - s) % w) +: 8];
        return old;
    endfunction

    task automatic init_mem();
        for (int j = 0; j < MSZ; j++) begin
            mem_model[j] = 8'(j);
            init_img[j]  = 8'(j);
        end
    endtask

    // Returns 1 when done appeared on ch; checks irq value and its distance from the last write.
    task automatic wait_done(input int ch, input bit exp_irq, output bit got);
        got = 0;
        for (int t = 0; t < 3000 && !got; t++) begin
            tick();
            if (done[ch]) got = 1;
        end
        check(got, "R7 done pulse seen", got, 1);
        if (got) begin
            check(irq[ch] == exp_irq, "R7 irq value at done", irq[ch], exp_irq);
            if (nwr > 0) check(cyc - last_cap == 2, "R7 done two cycles after last write",
                               cyc - last_cap, 2);
        end
    endtask

    task automatic compare_mem(input string tag);
        int bad, bj;
        bad = 0; bj = 0;
        for (int j = 0; j < MSZ; j++)
            if (mem_model[j] !== init_img[j] && bad++ == 0) bj = j;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s byte %0d actual=0x%0h expected=0x%0h", tag, bj,
                     mem_model[bj], init_img[bj]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got;
        int iter = 0;
        init_mem();
        repeat (3) @(negedge clk);
        // R10 reset state
        check({busy, mem_req, trig_o, done, irq} == '0, "R10 reset outputs",
              {busy, mem_req, trig_o, done, irq}, 0);
        rst_n = 1'b1;
        tick();
        check({busy, mem_req, trig_o} == '0, "R10 idle after reset", {busy, mem_req, trig_o}, 0);

        // Sweep of pattern mode, start offset and length (R1..R6, R11).
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
                for (int len = -1; len <= 10; len++) begin
                    int e, ch;
                    logic [31:0] v;
                    string tag;
                    if (s + len < 0) continue;
                    e = s + len;
                    ch = s % 2;
                    v = 32'h80808080 | (32'(iter) * 32'h01030507);
                    iter++;
                    init_mem();
                    for (int j = 0; j < MSZ; j++) init_img[j] = exp_byte(j, s, e, v, m, init_img[j]);
                    nwr = 0;
                    launch(ch, s, e, v, m);
                    wait_done(ch, (s != 0) && (e > s), got);
                    tick();
                    check(trig_o[ch] == 1'b0 && !busy, "R8 trigger cleared", {trig_o, busy}, 0);
                    if (e <= s)      tag = "R1 empty range memory";
                    else if (m == 0) tag = (s % 4 != 0) ? "R2 R6 2-byte fill" : "R2 2-byte fill";
                    else if (m == 1) tag = (s % 4 != 0) ? "R3 R6 3-byte fill" : "R3 3-byte fill";
                    else if (m == 2) tag = (s % 4 != 0) ? "R4 R6 4-byte fill" : "R4 4-byte fill";
                    else             tag = "R5 3-byte priority fill";
                    compare_mem(tag);
                    if (e <= s) check(nwr == 0, "R1 no writes", nwr, 0);
                end
            end
        end

        // R9: writes to the active channel are ignored, the other channel waits its turn.
        begin
            logic [31:0] v0, v1;
            int d1_early;
            v0 = 32'hC1C2C3C4;
            v1 = 32'hD5D6D7D8;
            init_mem();
            for (int j = 0; j < MSZ; j++) init_img[j] = exp_byte(j, 4, 40, v0, 2, init_img[j]);
            for (int j = 0; j < MSZ; j++) init_img[j] = exp_byte(j, 44, 49, v1, 0, init_img[j]);
            nwr = 0;
            launch(0, 4, 40, v0, 2);
            repeat (3) tick();
            cfg_wr(0, 2, 32'h99999999);
            cfg_wr(0, 0, 32'd50);
            cfg_wr(0, 3, 32'h1);
            launch(1, 44, 49, v1, 0);
            check(trig_o[1] == 1'b1 && busy, "R9 second channel pending", {trig_o, busy}, 3'b11);
            d1_early = 0;
            got = 0;
            for (int t = 0; t < 3000 && !got; t++) begin
                tick();
                if (done[1]) d1_early = 1;
                if (done[0]) got = 1;
            end
            check(got && !d1_early, "R9 channel 0 completes first", {got, d1_early}, 2'b10);
            check(irq[0] == 1'b1, "R7 channel 0 irq", irq[0], 1);
            wait_done(1, 1'b1, got);
            tick();
            check(trig_o == 2'b00, "R8 both triggers cleared", trig_o, 0);
            compare_mem("R9 ignored reconfiguration");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule